// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level AND-OR array whose connections come from configuration bits held in flip-flops. Each data input is split into a true and a complemented literal. A set of product terms each ANDs any chosen subset of those literals. Each output then ORs a chosen subset of the product terms. Only the configuration path is clocked. The path from the data inputs to the outputs is purely combinational.

The configuration is shifted in one bit per clock through a serial chain. A load strobe then copies the chain into a committed copy, and only the committed copy steers the array. A run-time mode input chooses how the OR plane behaves. In shared mode any product term may drive any number of outputs, under control of the OR mask. In grouped mode each output owns a fixed, contiguous group of terms and the OR mask is ignored, which models a fixed-OR array.

Top module: `sop_logic_array`

## Requirements
- R1: While reset is active and after it is released, the chain and the committed configuration are all zero, so `dout` is 0 for every `din` in both modes.
- R2: Chain bit `t*2*N_IN + 2*i` connects the true value of `din[i]` to product term t. Bit `t*2*N_IN + 2*i + 1` connects the complement of `din[i]` to term t.
- R3: A product term is the AND of its connected literals. A term that connects both the true and the complement of the same input is always 0.
- R4: A product term with no connected literal evaluates to 0 and cannot drive any output high.
- R5: In shared mode (`grp_mode`=0), `dout[o]` is the OR of every term t whose bit `AND_BITS + o*N_TERM + t` is set, where AND_BITS = N_TERM*2*N_IN. One term may feed several outputs.
- R6: In grouped mode (`grp_mode`=1), `dout[o]` is the OR of terms `o*G` to `o*G+G-1`, with G = N_TERM/N_OUT. The OR mask has no effect in this mode.
- R7: On each clock edge with `cfg_shift` high, the chain moves one place toward bit 0 and `cfg_sin` enters the top bit. After CFG_LEN shifts, the first bit sent sits at bit 0.
- R8: Shifting without a load leaves `dout` unchanged, because the array uses only the committed configuration.
- R9: On a clock edge with `cfg_load` high, the committed configuration takes the chain contents as they were before that edge. `dout` reflects the new configuration right after the edge.
- R10: A change of `grp_mode` or `din` changes `dout` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all configuration |
| cfg_sin | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift enable for the chain |
| cfg_load | input | 1 | Commit strobe, copies the chain to the active configuration |
| grp_mode | input | 1 | 0: shared OR plane, 1: fixed per-output term groups |
| din | input | N_IN | Data inputs |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
The assertions check the following properties on every cycle:
- the chain holds still without a shift, and each shift takes in the serial bit;
- the committed copy changes only on a load and then equals the previous chain contents;
- an empty product term never reads 1;
- no output is high unless a term that may feed it is high.

Only the bench scenarios can show the properties that depend on the whole truth table:
- the three example equations, compared exhaustively in both OR modes;
- the mapping of literal positions;
- a contradictory term reading 0;
- `dout` staying unchanged while a new configuration is shifted in but not yet committed.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Chain position of literal lit (2*i true, 2*i+1 complement) of term t.
  function automatic int and_bit_pos(input int t, input int lit, input int n_in);
    return t * 2 * n_in + lit;
  endfunction

  // Chain position of the OR connection from term t to output o.
  function automatic int or_bit_pos(input int o, input int t, input int n_term,
                                    input int and_bits);
    return and_bits + o * n_term + t;
  endfunction

  // Product of connected literals; an empty mask yields 0.
  function automatic logic term_value(input logic [63:0] lits, input logic [63:0] mask);
    return (|mask) & (&(lits | ~mask));
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int LEN = 66
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_sin,
  input  logic           cfg_shift,
  input  logic           cfg_load,
  output logic [LEN-1:0] active_q
);
  logic [LEN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q  <= '0;
      active_q <= '0;
    end else begin
      if (cfg_shift) chain_q <= {cfg_sin, chain_q[LEN-1:1]};
      if (cfg_load)  active_q <= chain_q;
    end
  end

  p_chain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(chain_q));
  p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> chain_q[LEN-1] == $past(cfg_sin));
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(active_q));
  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> active_q == $past(chain_q));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  localparam int LITS  = 2 * N_IN
) (
  input  logic [N_IN-1:0]        din,
  input  logic [N_TERM*LITS-1:0] and_mask,
  output logic [N_TERM-1:0]      term
);
  logic [LITS-1:0] lit_vec;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_vec[2*i]   = din[i];
    assign lit_vec[2*i+1] = ~din[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LITS-1:0] m;
    logic [63:0] m_w, l_w;
    assign m    = and_mask[t*LITS +: LITS];
    assign m_w  = 64'(m);
    assign l_w  = 64'(lit_vec);
    assign term[t] = term_value(l_w, m_w);

    always_comb begin
      p_empty_term_r4: assert (!(m == '0 && term[t] === 1'b1));
    end
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  localparam int GRP   = N_TERM / N_OUT
) (
  input  logic [N_TERM-1:0]       term,
  input  logic [N_OUT*N_TERM-1:0] or_mask,
  input  logic                    grp_mode,
  output logic [N_OUT-1:0]        dout
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic shared_v, grouped_v;
    assign shared_v  = |(term & or_mask[o*N_TERM +: N_TERM]);
    assign grouped_v = |term[o*GRP +: GRP];
    assign dout[o]   = grp_mode ? grouped_v : shared_v;

    always_comb begin
      p_grouped_source_r6: assert (!(grp_mode === 1'b1 && dout[o] === 1'b1
                                     && term[o*GRP +: GRP] == '0));
      p_shared_source_r5: assert (!(grp_mode === 1'b0 && dout[o] === 1'b1
                                    && (term & or_mask[o*N_TERM +: N_TERM]) == '0));
    end
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  localparam int AND_BITS = N_TERM * 2 * N_IN,
  localparam int OR_BITS  = N_OUT * N_TERM,
  localparam int CFG_LEN  = AND_BITS + OR_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sin,
  input  logic             cfg_shift,
  input  logic             cfg_load,
  input  logic             grp_mode,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);
  logic [CFG_LEN-1:0] active_cfg;
  logic [N_TERM-1:0]  term_vec;
  logic               commit_evt;

  assign commit_evt = cfg_load;

  sop_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .cfg_sin(cfg_sin), .cfg_shift(cfg_shift),
    .cfg_load(commit_evt), .active_q(active_cfg)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din(din), .and_mask(active_cfg[AND_BITS-1:0]), .term(term_vec)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term(term_vec), .or_mask(active_cfg[CFG_LEN-1:AND_BITS]),
    .grp_mode(grp_mode), .dout(dout)
  );

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> active_cfg == '0);
endmodule

// File: tb/tb_sop_logic_array.sv
module tb_sop_logic_array;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4, NO = 3, NT = 6;
  localparam int AB = NT * 2 * NI;
  localparam int CL = AB + NO * NT;

  logic clk = 0, rst_n = 0, cfg_sin = 0, cfg_shift = 0, cfg_load = 0, grp_mode = 0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;
  logic [CL-1:0] cv;
  int total = 0, bad = 0;

  sop_logic_array dut (.clk(clk), .rst_n(rst_n), .cfg_sin(cfg_sin), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .grp_mode(grp_mode), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [NO-1:0] exp);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s din=%b mode=%b actual=%b expected=%b", req, din, grp_mode, dout, exp);
    end
  endtask

  task automatic add_lit(input int t, input int i, input bit comp);
    cv[t*2*NI + 2*i + (comp ? 1 : 0)] = 1'b1;
  endtask
  task automatic add_or(input int o, input int t);
    cv[AB + o*NT + t] = 1'b1;
  endtask

  task automatic shift_cfg();
    for (int k = 0; k < CL; k++) begin
      @(negedge clk); cfg_sin = cv[k]; cfg_shift = 1;
    end
    @(negedge clk); cfg_shift = 0; cfg_sin = 0;
  endtask
  task automatic commit();
    @(negedge clk); cfg_load = 1;
    @(negedge clk); cfg_load = 0; #1;
  endtask

  function automatic logic [NO-1:0] ex_shared(input logic [NI-1:0] d);
    logic a, b, c, e;
    a = d[0]; b = d[1]; c = d[2]; e = d[3];
    return {(a&b) | (a&~c) | (~a&~b&~e),
            (a&~c) | (~a&c&e) | b,
            (a&b) | (~a&~b&~c&~e)};
  endfunction
  function automatic logic [NO-1:0] ex_grouped(input logic [NI-1:0] d);
    logic a, b, c, e;
    a = d[0]; b = d[1]; c = d[2]; e = d[3];
    return {b | (~a&~b&~e), (a&~c) | (~a&c&e), (a&b) | (~a&~b&~c&~e)};
  endfunction

  task automatic build_example();
    cv = '0;
    add_lit(0,0,0); add_lit(0,1,0);
    add_lit(1,0,1); add_lit(1,1,1); add_lit(1,2,1); add_lit(1,3,1);
    add_lit(2,0,0); add_lit(2,2,1);
    add_lit(3,0,1); add_lit(3,2,0); add_lit(3,3,0);
    add_lit(4,1,0);
    add_lit(5,0,1); add_lit(5,1,1); add_lit(5,3,1);
    add_or(0,0); add_or(0,1);
    add_or(1,2); add_or(1,3); add_or(1,4);
    add_or(2,0); add_or(2,2); add_or(2,5);
  endtask

  task automatic t_reset();
    for (int v = 0; v < 16; v += 5) begin
      din = v[NI-1:0]; grp_mode = v[0]; #1; check("R1 reset", '0);
    end
    grp_mode = 0;
  endtask

  task automatic t_example();
    build_example(); shift_cfg(); commit();
    for (int v = 0; v < 16; v++) begin
      din = v[NI-1:0]; grp_mode = 0; #1; check("R5 R7 shared example", ex_shared(din));
      grp_mode = 1; #1; check("R6 R10 grouped example", ex_grouped(din));
    end
    grp_mode = 0;
  endtask

  task automatic t_hold();
    logic [NO-1:0] ref_v;
    din = 4'b0011; #1; ref_v = dout;
    cv = '0; add_or(0,0);
    for (int k = 0; k < CL; k++) begin
      @(negedge clk); cfg_sin = cv[k]; cfg_shift = 1;
      if (k % 17 == 0) begin #1; check("R8 no effect before load", ref_v); end
    end
    @(negedge clk); cfg_shift = 0; #1; check("R8 no effect before load", ref_v);
    commit();
    check("R9 load commits", '0);
  endtask

  task automatic t_complement();
    cv = '0; add_lit(0,2,1); add_or(0,0); shift_cfg(); commit();
    for (int v = 0; v < 16; v++) begin
      din = v[NI-1:0]; #1; check("R2 complement literal", {2'b00, ~din[2]});
    end
  endtask

  task automatic t_contradict();
    cv = '0; add_lit(0,1,0); add_lit(0,1,1); add_or(0,0); add_or(2,0);
    shift_cfg(); commit();
    for (int v = 0; v < 16; v += 3) begin
      din = v[NI-1:0]; #1; check("R3 contradictory term", '0);
    end
  endtask

  task automatic t_empty();
    cv = '0;
    for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) add_or(o, t);
    shift_cfg(); commit();
    for (int v = 0; v < 16; v += 3) begin
      din = v[NI-1:0]; grp_mode = 0; #1; check("R4 empty term shared", '0);
      grp_mode = 1; #1; check("R4 empty term grouped", '0);
    end
    grp_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_example();
    t_hold();
    t_complement();
    t_contradict();
    t_empty();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule